// File: doc/BRIEF.md
# PCM Transmit Slot Serializer with Signaling

This block places one 8-bit PCM code per frame onto a serial line shared by several channels. Everything runs on the rising edge of the transmit bit clock. A frame starts at the first clock edge at which frame sync is seen high after being low. The block counts clock cycles from that point to reach its assigned time slot, which is chosen by a slot number input. During that slot it drives the code out one bit per cycle, most significant bit first. At all other times the data line is released: the output enable is low and the data is held at 0. An active-low strobe is asserted for exactly the cycles in which the line is driven, so it can enable an external bus driver.

Frame sync also carries in-band signaling. The block samples frame sync again one edge after the leading edge. If it is still high, the frame is a signaling frame. In a signaling frame the last bit of the slot carries the signaling input instead of the code's least significant bit. The code sent in any slot is the value that was present on the parallel input when the previous frame's slot ended. This gives one frame of pipelining between sampling and transmission.

The control FSM has five states. `ST_OFF` is the powered-down state. `ST_WAIT` waits for the first frame sync. `ST_COUNT` counts toward the slot. `ST_SEND` shifts the bits out. `ST_DONE` is the state after the slot, waiting for the next frame. The transitions are:
- Enable high moves `ST_OFF` to `ST_WAIT`.
- A leading edge moves `ST_WAIT`, `ST_COUNT`, `ST_SEND` or `ST_DONE` to `ST_COUNT`, with the cycle count restarted.
- Reaching the slot start moves `ST_COUNT` to `ST_SEND`.
- The eighth bit done moves `ST_SEND` to `ST_DONE`.
- Enable low from any state goes to `ST_OFF`.

Top module: `pcm_tx_slot_ser`

## Requirements
- R1: After reset the output enable is low, the strobe is high and the data output is 0.
- R2: With slot number value n (0 selects the first slot), the output is driven in exactly the 8 consecutive cycles that follow clock edges 1+8n through 8+8n. Edge 0 is the edge at which frame sync is first sampled high after being low.
- R3: Bits leave most significant first, one per clock cycle.
- R4: When the output enable is low, the data output is 0, and no drive happens outside the slot.
- R5: The strobe is low in exactly the cycles in which the output enable is high.
- R6: If frame sync is still high at edge 1, the frame is a signaling frame. Its final slot bit is the signaling input sampled at the edge that launches that bit.
- R7: In a frame where frame sync is high for one edge only, all 8 code bits are sent unchanged.
- R8: The parallel code is captured at the edge that ends the slot and is sent in the next frame's slot.
- R9: While enable is low the line stays released and the strobe high, even across frame syncs. The held code is cleared, so the first slot after re-enabling sends 0x00.
- R10: While inhibit is high the line stays released and the strobe high. Slot timing and code capture continue, so the next uninhibited slot sends the code captured during the inhibited frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block powered up when high |
| inhibit | input | 1 | Suppresses drive and strobe when high |
| fsync | input | 1 | Frame sync; its width selects signaling frames |
| slot_num | input | SLOT_W | Assigned slot, 0 = first slot |
| pcm_code | input | BITS | Parallel code to transmit next frame |
| sig_in | input | 1 | Signaling bit for signaling frames |
| sdata | output | 1 | Serial data, 0 when released |
| sdata_oe | output | 1 | High while the serial line is driven |
| slot_n | output | 1 | Active-low slot strobe |

## Verification
The bench builds the block with its defaults: 8-bit codes and a 6-bit slot number, giving 64 slots. Because of that, both the first slot, which starts one edge after the leading edge, and the last slot, which starts 505 edges after it, can be reached inside a short frame loop. Narrow and widened frame syncs are mixed so that both values of the signaling bit replace the least significant bit. The signaling input holds the opposite value on every edge except the sampling one. Inhibited frames and powered-down frames are placed between normal ones, which shows how each affects the held code.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_COUNT = 3'd2,
        ST_SEND  = 3'd3,
        ST_DONE  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/pcm_tx_fs_edge.sv
module pcm_tx_fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic lead
);
    logic fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    // high in the cycle whose closing edge sees the first high sample
    assign lead = fsync && !fs_q;
endmodule

// File: rtl/pcm_tx_shreg.sv
module pcm_tx_shreg #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic            last,
    input  logic            sub_en,
    input  logic            sub_bit,
    input  logic [BITS-1:0] code,
    output logic            msb
);
    logic [BITS-1:0] sh_q;
    logic [BITS-1:0] sh_shift;

    always_comb begin
        sh_shift = {sh_q[BITS-2:0], 1'b0};
        if (last && sub_en) sh_shift[BITS-1] = sub_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= code;
        else if (shift) sh_q <= sh_shift;
    end

    assign msb = sh_q[BITS-1];
endmodule

// File: rtl/pcm_tx_slot_ser.sv
module pcm_tx_slot_ser
    import pcm_tx_pkg::*;
#(
    parameter int BITS   = 8,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              inhibit,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] slot_num,
    input  logic [BITS-1:0]   pcm_code,
    input  logic              sig_in,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              slot_n
);
    localparam int POS_W = SLOT_W + $clog2(BITS) + 2;

    tx_state_e        state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_nx, slot_start, slot_last, slot_end;
    logic             sig_frame_q;
    logic [BITS-1:0]  code_hold_q;
    logic             lead, msb, load, last;

    pcm_tx_fs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .lead  (lead)
    );

    assign pos_nx     = pos_q + POS_W'(1);
    assign slot_start = POS_W'(1) + POS_W'(slot_num) * POS_W'(BITS);
    assign slot_last  = slot_start + POS_W'(BITS - 1);
    assign slot_end   = slot_start + POS_W'(BITS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_WAIT;
            ST_WAIT:  if (lead) state_d = ST_COUNT;
            ST_COUNT: begin
                if (lead)                      state_d = ST_COUNT;
                else if (pos_nx == slot_start) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (lead)                    state_d = ST_COUNT;
                else if (pos_nx == slot_end) state_d = ST_DONE;
            end
            ST_DONE:  if (lead) state_d = ST_COUNT;
            default:  state_d = ST_OFF;
        endcase
        if (!en) state_d = ST_OFF;
    end

    // frame counter, frame type and held code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= '0;
            sig_frame_q <= 1'b0;
            code_hold_q <= '0;
        end else begin
            if (lead)
                pos_q <= '0;
            else if (state_q == ST_COUNT || state_q == ST_SEND)
                pos_q <= pos_nx;

            if (lead)
                sig_frame_q <= 1'b0;
            else if (state_q == ST_COUNT && pos_q == '0 && fsync)
                sig_frame_q <= 1'b1;

            if (state_q == ST_OFF)
                code_hold_q <= '0;
            else if (state_q == ST_SEND && state_d == ST_DONE)
                code_hold_q <= pcm_code;
        end
    end

    assign load = (state_q == ST_COUNT) && (state_d == ST_SEND);
    assign last = (pos_nx == slot_last);

    pcm_tx_shreg #(.BITS(BITS)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (state_q == ST_SEND),
        .last    (last),
        .sub_en  (sig_frame_q),
        .sub_bit (sig_in),
        .code    (code_hold_q),
        .msb     (msb)
    );

    // outputs
    always_comb begin
        sdata_oe = (state_q == ST_SEND) && !inhibit;
        slot_n   = !sdata_oe;
        sdata    = sdata_oe && msb;
    end
endmodule

// File: rtl/pcm_tx_slot_ser_chk.sv
module pcm_tx_slot_ser_chk #(
    parameter int BITS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic inhibit,
    input logic fsync,
    input logic sdata,
    input logic sdata_oe,
    input logic slot_n
);
    logic [$clog2(BITS)+1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_cnt <= '0;
        else if (sdata_oe) run_cnt <= run_cnt + 1'b1;
        else               run_cnt <= '0;
    end

    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= ($clog2(BITS)+2)'(BITS));

    // R2
    lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !$past(fsync)) |=> !sdata_oe);

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata);

    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sdata_oe && slot_n));

    // R10
    inh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (!sdata_oe && slot_n));
endmodule

bind pcm_tx_slot_ser pcm_tx_slot_ser_chk #(.BITS(BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .inhibit  (inhibit),
    .fsync    (fsync),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .slot_n   (slot_n)
);

// File: tb/sim_pcm_tx_slot_ser.sv
module sim_pcm_tx_slot_ser;
    localparam int BITS   = 8;
    localparam int SLOT_W = 6;

    typedef struct {
        logic  b;
        int    at;
        string req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b1;
    logic              inhibit = 1'b0;
    logic              fsync = 1'b0;
    logic [SLOT_W-1:0] slot_num = '0;
    logic [BITS-1:0]   pcm_code = '0;
    logic              sig_in = 1'b0;
    logic              sdata, sdata_oe, slot_n;

    int        checks = 0;
    int        fails = 0;
    int        cyc = 0;
    logic      fs_prev = 1'b0;
    item_t     q[$];
    logic [7:0] prev_code = 8'h00;

    always #2 clk = ~clk;

    pcm_tx_slot_ser #(.BITS(BITS), .SLOT_W(SLOT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .inhibit(inhibit), .fsync(fsync),
        .slot_num(slot_num), .pcm_code(pcm_code), .sig_in(sig_in),
        .sdata(sdata), .sdata_oe(sdata_oe), .slot_n(slot_n)
    );

    // cycles since the last frame-sync leading edge
    always @(posedge clk) begin
        if (fsync && !fs_prev) cyc <= 0;
        else                   cyc <= cyc + 1;
        fs_prev <= fsync;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            check(slot_n === !sdata_oe, "R5", "strobe vs enable", int'(slot_n), int'(!sdata_oe));
            if (sdata_oe === 1'b1) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4", "drive outside any expected slot at cycle", cyc, -1);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(sdata === it.b, it.req, "bit value", int'(sdata), int'(it.b));
                    check(cyc == it.at, "R2", "bit position", cyc, it.at);
                end
            end else begin
                check(sdata === 1'b0, "R4", "released data level", int'(sdata), 0);
            end
        end
    end

    // one frame: expect = push expected bits, capture = code becomes next prev
    task automatic frame(input int slot, input logic [7:0] code, input bit wide,
                         input logic sigb, input bit expect_out, input bit capture,
                         input string req);
        int         s;
        int         len;
        logic [7:0] exp_code;
        s   = 1 + 8 * slot;
        len = s + 12;
        exp_code = prev_code;
        if (wide) exp_code[0] = sigb;
        @(negedge clk);
        slot_num = SLOT_W'(slot);
        pcm_code = code;
        sig_in   = ~sigb;
        fsync    = 1'b1;
        if (expect_out)
            for (int i = 0; i < 8; i++) q.push_back('{exp_code[7-i], s + i, req});
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            fsync  = (c == 0) && wide;
            sig_in = (c + 1 == s + 7) ? sigb : ~sigb;
        end
        check(q.size() == 0, "R2", "bits missing at end of frame", q.size(), 0);
        q.delete();
        if (capture) prev_code = code;
    endtask

    initial begin
        #801000;
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sdata_oe === 1'b0, "R1", "oe after reset", int'(sdata_oe), 0);
        check(slot_n === 1'b1, "R1", "strobe after reset", int'(slot_n), 1);
        check(sdata === 1'b0, "R1", "data after reset", int'(sdata), 0);

        frame(0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, "R7");  // sends 00, first slot
        frame(3, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, "R8");  // sends A5
        frame(5, 8'h81, 1'b1, 1'b1, 1'b1, 1'b1, "R6");  // sends 3D
        frame(2, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, "R6");  // sends 80
        frame(63, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R3"); // sends FF, last slot
        frame(1, 8'h69, 1'b0, 1'b0, 1'b1, 1'b1, "R7");  // sends 00

        // R10: inhibited frame, capture goes on
        @(negedge clk);
        inhibit = 1'b1;
        frame(1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        @(negedge clk);
        inhibit = 1'b0;
        frame(4, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, "R10"); // sends 5A

        // R9: powered-down frame, then re-enable sends 00
        @(negedge clk);
        en = 1'b0;
        frame(0, 8'hE7, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        @(negedge clk);
        en = 1'b1;
        prev_code = 8'h00;
        frame(4, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1, "R9");  // sends 00
        frame(2, 8'h34, 1'b1, 1'b1, 1'b1, 1'b1, "R8");  // sends 13

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule